// File: doc/BRIEF.md
# Sync-Driven Frequency Compensation Calculator

This block closes a frequency-locking loop for a counter clock that is ticked by an accumulator. Each time a synchronization pulse arrives, the block records where the local time counter stands and compares how far it advanced since the previous pulse with how far it still has to go to meet the master's time at the next pulse. The target is the received master time, plus the measured message delay, plus one sync period. The block then scales the present compensation word by the ratio of the count still needed to the count that elapsed. The rate of the local clock is corrected this way, and its count is never overwritten.

The scaling is a full-width multiply of the 32-bit word by the 64-bit needed count. A 96-bit by 64-bit restoring division follows it, one quotient bit per cycle. The new word appears on `word_o` together with a one-cycle `valid_o` strobe a fixed number of clock cycles after the sync edge. The update is withheld on the first pulse after reset, because no earlier capture exists yet. It is also withheld when the elapsed count is zero or when the quotient would not fit in 32 bits.

Top module: `freq_comp_calc`

## Requirements
- R1: After reset `valid_o` is 0 and `word_o` holds the nominal word `NOM_WORD` (default 32'hD5555555).
- R2: The first `sync_i` pulse after reset produces no `valid_o` strobe and leaves `word_o` unchanged.
- R3: On every later pulse the result is floor(W * N / E). W is `word_i` sampled at the sync edge. N = master + delay + period − C, taken modulo 2^64, where master, delay, period and C (`local_cnt_i`) are all sampled at that edge. E = C − P, modulo 2^64, where P is the count sampled at the previous pulse.
- R4: `valid_o` is high for exactly one cycle, starting at the clock edge `LATENCY` (default 50) edges after the sync edge. `word_o` takes its new value at that same edge and changes at no other time.
- R5: When E is zero, no strobe is issued and `word_o` keeps its value.
- R6: When W*N ≥ E*2^32, meaning the quotient needs more than 32 bits, no strobe is issued and `word_o` keeps its value.
- R7: Inputs are sampled only at the sync edge. Changing them during the computation has no effect on the result.
- R8: A new `sync_i` pulse during a computation abandons the old one. Only the result for the newer pulse is issued, `LATENCY` edges after it, and it uses the older pulse's count as P.
- R9: The product W*N is kept at 96 bits, so the result is exact even when the product exceeds 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | One-cycle synchronization pulse |
| master_time_i | input | 64 | Received master time reading |
| delay_i | input | 64 | Measured message transmission delay |
| period_i | input | 64 | Sync period in clock counts |
| local_cnt_i | input | 64 | Current local time count |
| word_i | input | 32 | Compensation word now in use |
| word_o | output | 32 | Latest computed compensation word |
| valid_o | output | 1 | One-cycle strobe on a new word |

## Verification
The hardest situations to reach from the ports are the suppressed updates: a repeated count that gives zero elapsed time, and a quotient that spills past 32 bits. Both depend on the previous capture as well as the present one. The stimulus table chains its pulses so that each entry's local count becomes the next entry's reference. It places a repeated count, an overflowing ratio and a product wider than 64 bits at chosen points in that chain. A restart case fires a second pulse ten cycles after the first, while the divider is still running, to show that only the later result is strobed.

// File: rtl/freq_comp_pkg.sv
package freq_comp_pkg;
  localparam int unsigned CNT_W_DEF   = 64;
  localparam int unsigned WORD_W_DEF  = 32;
  localparam int unsigned LATENCY_DEF = 50;
  localparam logic [31:0] NOM_WORD_DEF = 32'hD555_5555;  // 2^32 / 1.2
endpackage

// File: rtl/fcc_capture.sv
module fcc_capture #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] local_cnt_i,
  input  logic [CNT_W-1:0] master_time_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             have_prev_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic [CNT_W-1:0] needed_o
);
  logic [CNT_W-1:0] cur_q, prev_q, target_q;
  logic             seen_q, have_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      prev_q      <= '0;
      target_q    <= '0;
      seen_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (sync_i) begin
      prev_q      <= cur_q;
      cur_q       <= local_cnt_i;
      target_q    <= master_time_i + delay_i + period_i;
      have_prev_q <= seen_q;
      seen_q      <= 1'b1;
    end
  end

  assign have_prev_o = have_prev_q;
  assign elapsed_o   = cur_q - prev_q;
  assign needed_o    = target_q - cur_q;

  assert_prev_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> prev_q == $past(cur_q));
  assert_first_no_prev_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen_q) |-> !have_prev_q);
endmodule

// File: rtl/fcc_divider.sv
module fcc_divider #(
  parameter int unsigned DEN_W = 64,
  parameter int unsigned Q_W   = 32,
  localparam int unsigned NUM_W = DEN_W + Q_W,
  localparam int unsigned CW    = $clog2(Q_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic [Q_W-1:0]   quot_o,
  output logic             ovf_o,
  output logic             done_o
);
  logic [DEN_W-1:0] rem_q, den_q;
  logic [Q_W-1:0]   lo_q, quot_q;
  logic [CW-1:0]    bit_cnt_q;
  logic             busy_q, done_q, ovf_q;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem_q, lo_q[Q_W-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      den_q     <= '0;
      lo_q      <= '0;
      quot_q    <= '0;
      bit_cnt_q <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (start_i) begin
      // high part is below divisor unless overflow, so quotient fits Q_W bits
      rem_q     <= dividend_i[NUM_W-1:Q_W];
      lo_q      <= dividend_i[Q_W-1:0];
      den_q     <= divisor_i;
      quot_q    <= '0;
      bit_cnt_q <= CW'(Q_W);
      ovf_q     <= (divisor_i == '0) || (dividend_i >= {divisor_i, {Q_W{1'b0}}});
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
    end else if (busy_q) begin
      rem_q     <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      lo_q      <= {lo_q[Q_W-2:0], 1'b0};
      quot_q    <= {quot_q[Q_W-2:0], take};
      bit_cnt_q <= bit_cnt_q - 1'b1;
      if (bit_cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign quot_o = quot_q;
  assign ovf_o  = ovf_q;
  assign done_o = done_q;

  assert_busy_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> bit_cnt_q != '0);
  assert_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !ovf_q) |-> rem_q < den_q);
endmodule

// File: rtl/freq_comp_calc.sv
module freq_comp_calc
  import freq_comp_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned LATENCY  = LATENCY_DEF,
  parameter logic [WORD_W-1:0] NOM_WORD = NOM_WORD_DEF,
  localparam int unsigned PROD_W  = CNT_W + WORD_W,
  localparam int unsigned LAT_W   = $clog2(LATENCY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  master_time_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  local_cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  if (LATENCY < WORD_W + 3) begin : g_lat_chk
    $error("LATENCY too short for divider");
  end

  logic              have_prev;
  logic [CNT_W-1:0]  elapsed, needed;
  logic [WORD_W-1:0] word_q, quot, word_oq;
  logic [PROD_W-1:0] prod_q;
  logic [LAT_W-1:0]  cyc_q;
  logic              run_q, valid_q, div_ovf, div_done;
  logic              at_prod, at_start, at_load, upd_ok;

  fcc_capture #(.CNT_W(CNT_W)) i_capture (
    .clk_i, .rst_ni, .sync_i, .local_cnt_i, .master_time_i, .delay_i, .period_i,
    .have_prev_o(have_prev), .elapsed_o(elapsed), .needed_o(needed)
  );

  assign at_prod  = run_q && !sync_i && (cyc_q == LAT_W'(1));
  assign at_start = run_q && !sync_i && (cyc_q == LAT_W'(2));
  assign at_load  = run_q && !sync_i && (cyc_q == LAT_W'(LATENCY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      run_q  <= 1'b0;
      word_q <= '0;
      prod_q <= '0;
    end else begin
      if (sync_i) begin
        cyc_q  <= LAT_W'(1);
        run_q  <= 1'b1;
        word_q <= word_i;
      end else if (run_q) begin
        cyc_q <= cyc_q + 1'b1;
        if (at_load) run_q <= 1'b0;
      end
      if (at_prod) prod_q <= PROD_W'(word_q) * PROD_W'(needed);
    end
  end

  fcc_divider #(.DEN_W(CNT_W), .Q_W(WORD_W)) i_divider (
    .clk_i, .rst_ni, .start_i(at_start), .dividend_i(prod_q), .divisor_i(elapsed),
    .quot_o(quot), .ovf_o(div_ovf), .done_o(div_done)
  );

  assign upd_ok = have_prev && (elapsed != '0) && !div_ovf && div_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_oq <= NOM_WORD;
      valid_q <= 1'b0;
    end else begin
      valid_q <= at_load && upd_ok;
      if (at_load && upd_ok) word_oq <= quot;
    end
  end

  assign word_o  = word_oq;
  assign valid_o = valid_q;

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_word_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o);
  assert_no_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> have_prev);
  assert_nonzero_den_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(elapsed) != '0);
endmodule

// File: tb/test_freq_comp_calc.sv
module test_freq_comp_calc;
  localparam int LAT = 50;
  localparam int NV  = 7;
  localparam logic [31:0] NOM = 32'hD555_5555;

  // chained vectors: each local count is the next entry's reference
  localparam logic [63:0] V_LOC [NV] = '{64'd1000, 64'd1_001_000, 64'd2_001_000,
    64'd2_001_000, 64'd3_000_000, 64'h0000_1000_002D_C6C0, 64'h0000_1000_0037_0000};
  localparam logic [63:0] V_MST [NV] = '{64'd5, 64'd1_000_500, 64'd2_001_300,
    64'd2_001_000, 64'd6_000_000, 64'h0000_1000_002D_C6C0 - 64'd12345, 64'h0000_1000_0037_0100};
  localparam logic [63:0] V_DLY [NV] = '{64'd7, 64'd200, 64'd200, 64'd0, 64'd0, 64'd0, 64'd50};
  localparam logic [63:0] V_PER [NV] = '{64'd1_000_000, 64'd1_000_000, 64'd1_000_000,
    64'd1_000_000, 64'd1_000_000, 64'h0000_1000_0000_0000, 64'd600_000};
  localparam logic [31:0] V_WRD [NV] = '{32'h1234_5678, 32'hD555_5555, 32'hD500_0000,
    32'hD500_0000, 32'hF000_0000, 32'hFFFF_0000, 32'h0010_0000};

  logic        clk_i = 1'b0, rst_ni = 1'b0, sync_i = 1'b0;
  logic [63:0] master_time_i = '0, delay_i = '0, period_i = '0, local_cnt_i = '0;
  logic [31:0] word_i = '0, word_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_prev;
  bit          m_seen;
  logic [31:0] m_word;

  freq_comp_calc i_freq_comp_calc (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model(input logic [63:0] loc, mst, dly, per, input logic [31:0] w,
                               output logic [31:0] q);
    logic [127:0] p, e, n;
    bit ok;
    e = 128'(loc - m_prev);
    n = 128'(64'(mst + dly + per - loc));
    p = 128'(w) * n;
    ok = m_seen && (e != 0) && (p < (e << 32));
    q = ok ? 32'(p / e) : 32'h0;
    m_prev = loc;
    m_seen = 1'b1;
    return ok;
  endfunction

  task automatic drive(input logic [63:0] loc, mst, dly, per, input logic [31:0] w);
    @(negedge clk_i);
    local_cnt_i = loc; master_time_i = mst; delay_i = dly; period_i = per; word_i = w;
    sync_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    sync_i = 1'b0;
    // R7: scramble inputs during computation
    local_cnt_i = ~loc; master_time_i = ~mst; delay_i = 64'hDEAD; period_i = 64'h1; word_i = ~w;
  endtask

  task automatic observe(input bit exp_upd, input logic [31:0] exp_w, input string req);
    int n_valid = 0, at = -1;
    logic [31:0] w_at = '0;
    for (int k = 1; k <= LAT + 6; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (valid_o) begin
        n_valid++; at = k; w_at = word_o;
      end
    end
    if (exp_upd) begin
      check(n_valid == 1 && at == LAT, {req, " R4 strobe timing"}, 64'(at), 64'(LAT));
      check(w_at == exp_w, {req, " R3 word"}, 64'(w_at), 64'(exp_w));
      check(word_o == exp_w, {req, " R4 word held"}, 64'(word_o), 64'(exp_w));
      m_word = exp_w;
    end else begin
      check(n_valid == 0, {req, " no strobe"}, 64'(n_valid), 64'd0);
      check(word_o == m_word, {req, " word kept"}, 64'(word_o), 64'(m_word));
    end
  endtask

  initial begin
    for (int c = 0; c < 200_000; c++) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    bit ok;
    m_prev = '0; m_seen = 1'b0; m_word = NOM;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid at reset", 64'(valid_o), 64'd0);
    check(word_o == NOM, "R1 word at reset", 64'(word_o), 64'(NOM));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      string tag;
      ok = model(V_LOC[i], V_MST[i], V_DLY[i], V_PER[i], V_WRD[i], q);
      case (i)
        0: tag = "R2 first sync";
        3: tag = "R5 zero elapsed";
        4: tag = "R6 quotient overflow";
        5: tag = "R9 wide product";
        default: tag = "R3 R7 update";
      endcase
      drive(V_LOC[i], V_MST[i], V_DLY[i], V_PER[i], V_WRD[i]);
      observe(ok, q, tag);
    end
    check(m_word != NOM, "R9 wide product updated", 64'(m_word), 64'(NOM));

    // R8: restart while dividing
    ok = model(64'h0000_1000_0040_0000, 64'd0, 64'd0, 64'd0, 32'h1, q);
    drive(64'h0000_1000_0040_0000, 64'd0, 64'd0, 64'd0, 32'h1);
    repeat (8) @(negedge clk_i);
    ok = model(64'h0000_1000_0041_0000, 64'h0000_1000_0041_0100, 64'd0, 64'h1_0000, 32'h0080_0000, q);
    drive(64'h0000_1000_0041_0000, 64'h0000_1000_0041_0100, 64'd0, 64'h1_0000, 32'h0080_0000);
    observe(ok, q, "R8 restart");
    check(ok, "R8 restart expects update", 64'(ok), 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule